// File: doc/BRIEF.md
# Load-Use Stall Detector with Pipeline Front Registers

This block finds the one case in a five-stage in-order pipeline that operand forwarding cannot cover: a memory load whose result is needed by the instruction right behind it. While the consumer sits in decode, the detector looks at the instruction one stage ahead in the ID/EX register. If that instruction reads memory and its destination register is one of the consumer's two source fields, the pipeline is held for a single cycle.

The hold works through write enables rather than a clock gate. The program counter and the IF/ID register have write enables that are high on every ordinary cycle and drop only for the stall cycle, so both registers keep their contents. In that cycle the ID/EX register takes an all-zero control word, which turns the held instruction into a no-op for one pass. The load moves on into EX/MEM unchanged. A thin wrapper holds the PC, IF/ID, ID/EX and EX/MEM registers and a small decoder, so that the stall can be watched across cycles. Forwarding, branches and arithmetic are handled elsewhere.

Top module: `lu_hazard_pipe`

## Requirements
- R1: `stall` is high exactly when the ID/EX control word has its memory-read bit (bit 0 of `idex_ctrl`) set, `idex_rt` is nonzero, and `idex_rt` equals the source field in bits [25:21] or the one in bits [20:16] of `ifid_instr`.
- R2: A destination of register 0 never causes a stall, even when it matches a source field.
- R3: When the ID/EX memory-read bit is clear, `stall` stays low whatever the register fields hold. This includes stores and ALU operations.
- R4: `pc_we` is the inverse of `stall`. With `pc_we` high, `pc` advances by 4 at the next edge. With `pc_we` low, `pc` keeps its value.
- R5: `ifid_we` is the inverse of `stall`. With `ifid_we` high, IF/ID loads `imem_rdata` at the next edge. With it low, `ifid_instr` keeps its value.
- R6: `bubble` equals `stall`. With `bubble` high, `idex_ctrl` is all zero after the next edge. Otherwise it takes the decoded control of `ifid_instr`, and `idex_rt` always takes bits [20:16] of `ifid_instr`.
- R7: The load continues during the stall. At the edge that ends a stall cycle, EX/MEM (`exmem_ctrl`, `exmem_rt`) takes the ID/EX contents, memory-read bit included.
- R8: A stall lasts exactly one cycle. The cycle after a stall never stalls.
- R9: After reset, `pc`, `ifid_instr`, `idex_ctrl`, `idex_rt`, `exmem_ctrl` and `exmem_rt` are zero and `stall` is low.
- R10: Decoding uses the opcode in bits [31:26]. The control word bits are 0 memory read, 1 memory write, 2 register write, 3 ALU immediate source, and 4 destination from the rd field. Each opcode sets these bits:
  - opcode 100011 (load): bits 0, 2 and 3.
  - opcode 101011 (store): bits 1 and 3.
  - opcode 000000: bits 2 and 4.
  - any other opcode: bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_rdata | input | 32 | Instruction word fetched at `pc` |
| pc | output | 32 | Program counter |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | IF/ID write enable |
| bubble | output | 1 | Zero-control select for the ID/EX load |
| stall | output | 1 | Load-use hazard detected this cycle |
| ifid_instr | output | 32 | Instruction held in IF/ID |
| idex_ctrl | output | 5 | Control word in ID/EX |
| idex_rt | output | 5 | Destination (rt) field in ID/EX |
| exmem_ctrl | output | 5 | Control word in EX/MEM |
| exmem_rt | output | 5 | rt field in EX/MEM |

## Verification
The bound checker tests the following relations on every cycle:
- The stall condition, its register-0 exception and the non-load exception.
- The link between the three enable outputs and `stall`.
- That PC and IF/ID are held under a low enable.
- That ID/EX is zeroed after a bubble.
- That the load moves on into EX/MEM.
- That no stall repeats.

The bench runs a reference model against a program that mixes fixed hazard patterns with random instructions. Only these scenarios show the end-to-end effect:
- A dependent consumer runs once, after exactly one lost cycle.
- A chain of back-to-back dependent loads stalls twice.
- A load two instructions ahead never stalls.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;

  localparam int XLEN    = 32;
  localparam int RAW     = 5;
  localparam int OPW     = 6;
  localparam int OP_LSB  = XLEN - OPW;
  localparam int RS_LSB  = OP_LSB - RAW;
  localparam int RT_LSB  = RS_LSB - RAW;
  localparam int PC_STEP = XLEN / 8;
  localparam int NUM_SRC = 2;

  localparam logic [OPW-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPW-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPW-1:0] OPC_ALU   = 6'b000000;

  typedef struct packed {
    logic reg_dst;
    logic alu_src;
    logic reg_write;
    logic mem_write;
    logic mem_read;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [OPW-1:0] f_opcode(input logic [XLEN-1:0] w);
    return w[OP_LSB +: OPW];
  endfunction

  function automatic logic [RAW-1:0] f_rs(input logic [XLEN-1:0] w);
    return w[RS_LSB +: RAW];
  endfunction

  function automatic logic [RAW-1:0] f_rt(input logic [XLEN-1:0] w);
    return w[RT_LSB +: RAW];
  endfunction

  function automatic ctrl_t f_decode(input logic [XLEN-1:0] w);
    ctrl_t c;
    c = '0;
    unique case (f_opcode(w))
      OPC_LOAD: begin
        c.mem_read  = 1'b1;
        c.reg_write = 1'b1;
        c.alu_src   = 1'b1;
      end
      OPC_STORE: begin
        c.mem_write = 1'b1;
        c.alu_src   = 1'b1;
      end
      OPC_ALU: begin
        c.reg_write = 1'b1;
        c.reg_dst   = 1'b1;
      end
      default: begin
        c.reg_write = 1'b1;
        c.alu_src   = 1'b1;
      end
    endcase
    return c;
  endfunction

  function automatic logic f_live_match(input logic [RAW-1:0] dst,
                                        input logic [RAW-1:0] src);
    return (dst == src) && (dst != '0);
  endfunction

endpackage

// File: rtl/lu_decode.sv
module lu_decode
  import lu_hazard_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl,
  output logic [RAW-1:0]  rs,
  output logic [RAW-1:0]  rt
);

  always_comb begin
    ctrl = f_decode(instr);
    rs   = f_rs(instr);
    rt   = f_rt(instr);
  end

endmodule

// File: rtl/lu_loaduse_detect.sv
module lu_loaduse_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic              load_in_ex,
  input  logic [AW-1:0]     ex_dst,
  input  logic [NSRC*AW-1:0] id_srcs,
  output logic [NSRC-1:0]   src_hit,
  output logic              stall
);

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign src_hit[g] = (id_srcs[g*AW +: AW] == ex_dst) && (ex_dst != '0);
  end

  assign stall = load_in_ex && (|src_hit);

endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl (
  input  logic stall,
  output logic pc_we,
  output logic ifid_we,
  output logic bubble
);

  assign pc_we   = ~stall;
  assign ifid_we = ~stall;
  assign bubble  = stall;

endmodule

// File: rtl/lu_hazard_pipe.sv
module lu_hazard_pipe
  import lu_hazard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   imem_rdata,
  output logic [XLEN-1:0]   pc,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              bubble,
  output logic              stall,
  output logic [XLEN-1:0]   ifid_instr,
  output logic [CTRL_W-1:0] idex_ctrl,
  output logic [RAW-1:0]    idex_rt,
  output logic [CTRL_W-1:0] exmem_ctrl,
  output logic [RAW-1:0]    exmem_rt
);

  ctrl_t              dec_ctrl;
  logic [RAW-1:0]     dec_rs;
  logic [RAW-1:0]     dec_rt;
  ctrl_t              idex_q;
  ctrl_t              exmem_q;
  ctrl_t              idex_next;
  logic [NUM_SRC-1:0] src_hit;

  lu_decode u_dec (
    .instr (ifid_instr),
    .ctrl  (dec_ctrl),
    .rs    (dec_rs),
    .rt    (dec_rt)
  );

  lu_loaduse_detect #(.AW(RAW), .NSRC(NUM_SRC)) u_det (
    .load_in_ex (idex_q.mem_read),
    .ex_dst     (idex_rt),
    .id_srcs    ({dec_rt, dec_rs}),
    .src_hit    (src_hit),
    .stall      (stall)
  );

  lu_stall_ctrl u_sc (
    .stall   (stall),
    .pc_we   (pc_we),
    .ifid_we (ifid_we),
    .bubble  (bubble)
  );

  assign idex_next = bubble ? ctrl_t'('0) : dec_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= '0;
      ifid_instr <= '0;
      idex_q     <= '0;
      idex_rt    <= '0;
      exmem_q    <= '0;
      exmem_rt   <= '0;
    end else begin
      if (pc_we)   pc         <= pc + XLEN'(PC_STEP);
      if (ifid_we) ifid_instr <= imem_rdata;
      idex_q   <= idex_next;
      idex_rt  <= dec_rt;
      exmem_q  <= idex_q;
      exmem_rt <= idex_rt;
    end
  end

  assign idex_ctrl  = idex_q;
  assign exmem_ctrl = exmem_q;

endmodule

// File: rtl/lu_hazard_pipe_chk.sv
module lu_hazard_pipe_chk
  import lu_hazard_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              bubble,
  input logic              stall,
  input logic [XLEN-1:0]   ifid_instr,
  input logic [CTRL_W-1:0] idex_ctrl,
  input logic [RAW-1:0]    idex_rt,
  input logic [CTRL_W-1:0] exmem_ctrl
);

  logic dep_rs, dep_rt;
  assign dep_rs = (ifid_instr[RS_LSB +: RAW] == idex_rt);
  assign dep_rt = (ifid_instr[RT_LSB +: RAW] == idex_rt);

  p_hit_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_ctrl[0] && idex_rt != '0 && (dep_rs || dep_rt)) |-> stall);

  p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rt == '0) |-> !stall);

  p_nonload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_ctrl[0] |-> !stall);

  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc));

  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (pc == $past(pc) + XLEN'(PC_STEP)));

  p_ifid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_we |=> $stable(ifid_instr));

  p_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_we && !ifid_we && bubble));

  p_bubble_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (idex_ctrl == '0));

  p_load_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> exmem_ctrl[0]);

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

endmodule

bind lu_hazard_pipe lu_hazard_pipe_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc         (pc),
  .pc_we      (pc_we),
  .ifid_we    (ifid_we),
  .bubble     (bubble),
  .stall      (stall),
  .ifid_instr (ifid_instr),
  .idex_ctrl  (idex_ctrl),
  .idex_rt    (idex_rt),
  .exmem_ctrl (exmem_ctrl)
);

// File: tb/tb_lu_hazard_pipe.sv
`timescale 1ns/1ps
module tb_lu_hazard_pipe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_rdata;
  logic [31:0] pc;
  logic        pc_we, ifid_we, bubble, stall;
  logic [31:0] ifid_instr;
  logic [4:0]  idex_ctrl, idex_rt, exmem_ctrl, exmem_rt;

  logic [31:0] prog [64];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stalls_seen = 0;
  int zero_skips = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign imem_rdata = prog[pc[7:2]];

  lu_hazard_pipe dut (
    .clk(clk), .rst_n(rst_n), .imem_rdata(imem_rdata), .pc(pc),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble), .stall(stall),
    .ifid_instr(ifid_instr), .idex_ctrl(idex_ctrl), .idex_rt(idex_rt),
    .exmem_ctrl(exmem_ctrl), .exmem_rt(exmem_rt)
  );

  // reference state
  logic [31:0] m_pc, m_ifid;
  logic [4:0]  m_idex_c, m_idex_rt, m_exm_c, m_exm_rt;

  function automatic logic [31:0] mk(input logic [5:0] op, input int rs,
                                     input int rt, input logic [15:0] lo);
    return {op, 5'(rs), 5'(rt), lo};
  endfunction

  // R10 control bits: 0 rd-mem, 1 wr-mem, 2 wr-reg, 3 imm, 4 rd-field
  function automatic logic [4:0] ref_ctrl(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    if (op == 6'b100011) return 5'b01101;
    if (op == 6'b101011) return 5'b01010;
    if (op == 6'b000000) return 5'b10100;
    return 5'b01100;
  endfunction

  function automatic bit ref_stall(input logic [4:0] c, input logic [4:0] rt,
                                   input logic [31:0] w);
    bit hit = 0;
    if (c[0] && rt != 5'd0) begin
      if (w[25:21] == rt) hit = 1;
      if (w[20:16] == rt) hit = 1;
    end
    return hit;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    bit s;
    logic [5:0] ops [4];
    void'($urandom(32'd4242));
    ops[0] = 6'b100011; ops[1] = 6'b101011; ops[2] = 6'b000000; ops[3] = 6'b001000;
    // directed hazard patterns
    prog[0]  = mk(6'b100011, 1, 5, 16'h0);
    prog[1]  = mk(6'b000000, 5, 2, 16'h3020);   // rs dep: stall
    prog[2]  = mk(6'b100011, 2, 7, 16'h4);
    prog[3]  = mk(6'b000000, 3, 7, 16'h4022);   // rt dep: stall
    prog[4]  = mk(6'b100011, 1, 0, 16'h8);
    prog[5]  = mk(6'b000000, 0, 0, 16'h0);      // r0 match: none (R2)
    prog[6]  = mk(6'b101011, 4, 8, 16'hc);
    prog[7]  = mk(6'b000000, 8, 8, 16'h4820);   // after store: none (R3)
    prog[8]  = mk(6'b100011, 1, 9, 16'h10);
    prog[9]  = mk(6'b000000, 10, 11, 16'h6020); // independent
    prog[10] = mk(6'b100011, 1, 12, 16'h14);
    prog[11] = mk(6'b001000, 12, 13, 16'h1);    // imm dep: stall
    prog[12] = mk(6'b000000, 12, 12, 16'h0);    // load two back: none
    prog[13] = mk(6'b100011, 1, 14, 16'h18);
    prog[14] = mk(6'b100011, 14, 15, 16'h0);    // load chain: stall
    prog[15] = mk(6'b000000, 15, 3, 16'h0);     // stall again
    for (int i = 16; i < 64; i++)
      prog[i] = mk(ops[$urandom % 4], int'($urandom % 4), int'($urandom % 4),
                   16'($urandom));

    m_pc = 0; m_ifid = 0; m_idex_c = 0; m_idex_rt = 0; m_exm_c = 0; m_exm_rt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state, still in reset
    chk(pc == 0, "R9", pc, 0);
    chk(ifid_instr == 0, "R9", ifid_instr, 0);
    chk({idex_ctrl, idex_rt, exmem_ctrl, exmem_rt} == 0, "R9",
        {idex_ctrl, idex_rt, exmem_ctrl, exmem_rt}, 0);
    chk(!stall, "R9", stall, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 400; k++) begin
      s = ref_stall(m_idex_c, m_idex_rt, m_ifid);
      chk(stall == s, "R1", stall, s);
      if (m_idex_c[0] && m_idex_rt == 0 &&
          (m_ifid[25:21] == 0 || m_ifid[20:16] == 0)) begin
        zero_skips++;
        chk(!stall, "R2", stall, 0);
      end
      if (!m_idex_c[0]) chk(!stall, "R3", stall, 0);
      chk(pc_we == !s, "R4", pc_we, !s);
      chk(ifid_we == !s, "R5", ifid_we, !s);
      chk(bubble == s, "R6", bubble, s);
      chk(pc == m_pc, "R4", pc, m_pc);
      chk(ifid_instr == m_ifid, "R5", ifid_instr, m_ifid);
      chk(idex_ctrl == m_idex_c, "R6", idex_ctrl, m_idex_c);
      chk(idex_rt == m_idex_rt, "R6", idex_rt, m_idex_rt);
      chk(exmem_ctrl == m_exm_c, "R7", exmem_ctrl, m_exm_c);
      chk(exmem_rt == m_exm_rt, "R7", exmem_rt, m_exm_rt);
      if (s) stalls_seen++;
      // advance reference
      m_exm_c  = m_idex_c;
      m_exm_rt = m_idex_rt;
      m_idex_c = s ? 5'd0 : ref_ctrl(m_ifid);
      m_idex_rt = m_ifid[20:16];
      if (!s) begin
        m_ifid = prog[m_pc[7:2]];
        m_pc   = m_pc + 4;
      end
      @(posedge clk);
      @(negedge clk);
      if (s) begin
        chk(!stall, "R8", stall, 0);
        chk(exmem_ctrl[0], "R7", exmem_ctrl, 5'b00001);
      end
    end
    chk(stalls_seen > 0, "R1", stalls_seen, 1);
    chk(zero_skips > 0, "R2", zero_skips, 1);
    finish_run();
  end

endmodule